// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block translates virtual addresses to physical addresses through a fully associative table. Every entry describes an aligned pair of neighbouring virtual pages (one even, one odd) and gives each page its own physical frame base, valid bit and dirty bit. An entry also carries a page-size mask, an 8-bit address-space tag and a global flag that makes the entry match in any address space. All entries are compared against the request in parallel. The hit with the lowest index is then resolved into a translation or into a fault code.

Lookups arrive on a valid/ready request channel and leave on a valid/ready response channel held in a single output register. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or is being drained in the same cycle (`rsp_ready` high). The response appears in the cycle after acceptance. It stays on the pins, unchanged, until a cycle in which `rsp_ready` is high. The requester must hold `req_valid` and its payload stable until acceptance. Entries are loaded through a plain indexed write port with no handshake.

Top module: `tlb_pair_lookup`

## Requirements
- R1: An entry hits when its global flag is set or its 8-bit address-space tag equals `req_asid`, and its stored virtual page field equals `req_va` with all effective-mask bits cleared on both sides.
- R2: The effective mask of an entry is its written page mask ORed with the low `PG_SHIFT+1` bits (13 bits at the default 4 KiB page). Mask bits above bit 12 widen both pages of the pair together.
- R3: The odd frame is selected when the address bit at the highest set bit of the effective mask is 1, and the even frame is selected when it is 0.
- R4: If the selected frame's valid bit is clear, the response code is INVALID (2'd2), `rsp_phys` is 0 and `rsp_wperm` is 0.
- R5: A read, or a write to a frame whose dirty bit is set, gives code MATCH (2'd0) and `rsp_phys` = frame base OR (`req_va` AND (effective mask >> 1)).
- R6: A write to a valid frame whose dirty bit is clear gives code MODIFIED (2'd3), `rsp_phys` 0 and `rsp_wperm` 0.
- R7: `rsp_wperm` equals the dirty bit of the selected frame when the code is MATCH, and is 0 otherwise.
- R8: When no entry hits, the code is NOMATCH (2'd1), `rsp_phys` is 0 and `rsp_wperm` is 0.
- R9: When several entries hit, the lowest index decides the result, even if that result is a fault.
- R10: A response becomes valid in the cycle after acceptance. Under back-pressure it holds its value, and `req_ready` is low while a response waits with `rsp_ready` low. With no acceptance and with `rsp_ready` high, `rsp_valid` falls.
- R11: A write takes effect at the edge where `wr_en` is high, so a lookup accepted at that same edge sees the old contents. A write with `wr_idx` >= `N_ENTRIES` changes nothing.
- R12: Reset clears every field of every entry to zero and leaves `rsp_valid` low and `req_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | VA_W | Virtual address to translate |
| req_asid | input | ASID_W | Current address-space tag |
| req_write | input | 1 | 1 = store access, 0 = load access |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_code | output | 2 | 0 match, 1 no match, 2 invalid, 3 modified |
| rsp_phys | output | PA_W | Translated address (0 on any fault) |
| rsp_wperm | output | 1 | Selected frame allows stores |
| wr_en | input | 1 | Load one entry |
| wr_idx | input | IDX_W | Entry index to load |
| wr_vpn | input | VA_W | Virtual pair tag (masked bits ignored) |
| wr_pmask | input | VA_W | Page-size mask bits |
| wr_asid | input | ASID_W | Address-space tag of the entry |
| wr_global | input | 1 | Match in every address space |
| wr_pfn_even | input | PA_W | Physical base of the even page |
| wr_pfn_odd | input | PA_W | Physical base of the odd page |
| wr_v_even | input | 1 | Even page valid |
| wr_d_even | input | 1 | Even page writable |
| wr_v_odd | input | 1 | Odd page valid |
| wr_d_odd | input | 1 | Odd page writable |

## Verification
The bench builds the block with six entries, which is not a power of two. A three-bit index can then name slots 6 and 7, which do not exist, so the discard rule for writes to them is reached. Addresses and frames stay 32 bits wide and the page shift stays at 12. The bench writes masks for 4 KiB, 16 KiB and 64 KiB pages, so odd/even selection at several mask heights is exercised. With only six slots and a small range of tags and addresses, overlapping entries and same-edge write/lookup collisions occur often.

// File: rtl/tlb_pair_pkg.sv
package tlb_pair_pkg;
  typedef enum logic [1:0] {
    RES_MATCH    = 2'd0,
    RES_NOMATCH  = 2'd1,
    RES_INVALID  = 2'd2,
    RES_MODIFIED = 2'd3
  } tlb_res_e;
endpackage

// File: rtl/tlb_pair_store.sv
// Entry registers; the effective mask is formed once, at write time.
module tlb_pair_store #(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int PG_SHIFT  = 12,
  parameter int IDX_W     = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [VA_W-1:0]      wr_vpn,
  input  logic [VA_W-1:0]      wr_pmask,
  input  logic [ASID_W-1:0]    wr_asid,
  input  logic                 wr_global,
  input  logic [PA_W-1:0]      wr_pfn_even,
  input  logic [PA_W-1:0]      wr_pfn_odd,
  input  logic                 wr_v_even,
  input  logic                 wr_d_even,
  input  logic                 wr_v_odd,
  input  logic                 wr_d_odd,
  output logic [VA_W-1:0]      e_vpn   [N_ENTRIES],
  output logic [VA_W-1:0]      e_mask  [N_ENTRIES],
  output logic [ASID_W-1:0]    e_asid  [N_ENTRIES],
  output logic [PA_W-1:0]      e_pfn0  [N_ENTRIES],
  output logic [PA_W-1:0]      e_pfn1  [N_ENTRIES],
  output logic [N_ENTRIES-1:0] e_glob,
  output logic [N_ENTRIES-1:0] e_v0,
  output logic [N_ENTRIES-1:0] e_d0,
  output logic [N_ENTRIES-1:0] e_v1,
  output logic [N_ENTRIES-1:0] e_d1
);
  localparam logic [VA_W-1:0] MIN_MASK = VA_W'((64'd1 << (PG_SHIFT + 1)) - 64'd1);

  logic idx_ok;
  assign idx_ok = (32'(wr_idx) < N_ENTRIES);

  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
    logic sel_w;
    assign sel_w = wr_en && idx_ok && (32'(wr_idx) == i);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        e_vpn[i]  <= '0;
        e_mask[i] <= MIN_MASK;
        e_asid[i] <= '0;
        e_pfn0[i] <= '0;
        e_pfn1[i] <= '0;
        e_glob[i] <= 1'b0;
        e_v0[i]   <= 1'b0;
        e_d0[i]   <= 1'b0;
        e_v1[i]   <= 1'b0;
        e_d1[i]   <= 1'b0;
      end else if (sel_w) begin
        e_vpn[i]  <= wr_vpn;
        e_mask[i] <= wr_pmask | MIN_MASK;
        e_asid[i] <= wr_asid;
        e_pfn0[i] <= wr_pfn_even;
        e_pfn1[i] <= wr_pfn_odd;
        e_glob[i] <= wr_global;
        e_v0[i]   <= wr_v_even;
        e_d0[i]   <= wr_d_even;
        e_v1[i]   <= wr_v_odd;
        e_d1[i]   <= wr_d_odd;
      end
    end
  end
endmodule

// File: rtl/tlb_pair_cmp.sv
// Parallel tag/space comparison, one comparator per entry.
module tlb_pair_cmp #(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int ASID_W    = 8
) (
  input  logic [VA_W-1:0]      va,
  input  logic [ASID_W-1:0]    asid,
  input  logic [VA_W-1:0]      e_vpn  [N_ENTRIES],
  input  logic [VA_W-1:0]      e_mask [N_ENTRIES],
  input  logic [ASID_W-1:0]    e_asid [N_ENTRIES],
  input  logic [N_ENTRIES-1:0] e_glob,
  output logic [N_ENTRIES-1:0] hit
);
  for (genvar i = 0; i < N_ENTRIES; i++) begin : g_cmp
    logic space_ok;
    logic tag_ok;
    assign space_ok = e_glob[i] || (e_asid[i] == asid);
    assign tag_ok   = ((e_vpn[i] ^ va) & ~e_mask[i]) == '0;
    assign hit[i]   = space_ok && tag_ok;
  end
endmodule

// File: rtl/tlb_pair_pick.sv
// Lowest-index winner among the hit vector.
module tlb_pair_pick #(
  parameter int N_ENTRIES = 16,
  parameter int IDX_W     = 4
) (
  input  logic [N_ENTRIES-1:0] hit,
  output logic                 any_hit,
  output logic [IDX_W-1:0]     win_idx
);
  always_comb begin
    win_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) win_idx = IDX_W'(i);
    end
  end
  assign any_hit = |hit;
endmodule

// File: rtl/tlb_pair_xlate.sv
// Resolve the winning entry into a result code and address.
module tlb_pair_xlate
  import tlb_pair_pkg::*;
#(
  parameter int VA_W = 32,
  parameter int PA_W = 32
) (
  input  logic            any_hit,
  input  logic            is_write,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] mask,
  input  logic [PA_W-1:0] pfn0,
  input  logic [PA_W-1:0] pfn1,
  input  logic            v0,
  input  logic            d0,
  input  logic            v1,
  input  logic            d1,
  output tlb_res_e        code,
  output logic [PA_W-1:0] phys,
  output logic            wperm
);
  logic            odd;
  logic            fv;
  logic            fd;
  logic [PA_W-1:0] base;
  logic [VA_W-1:0] offs;

  assign odd  = |(va & mask & ~(mask >> 1));
  assign fv   = odd ? v1 : v0;
  assign fd   = odd ? d1 : d0;
  assign base = odd ? pfn1 : pfn0;
  assign offs = va & (mask >> 1);

  always_comb begin
    code  = RES_NOMATCH;
    phys  = '0;
    wperm = 1'b0;
    if (any_hit) begin
      if (!fv) begin
        code = RES_INVALID;
      end else if (is_write && !fd) begin
        code = RES_MODIFIED;
      end else begin
        code  = RES_MATCH;
        phys  = base | PA_W'(offs);
        wperm = fd;
      end
    end
  end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup
  import tlb_pair_pkg::*;
#(
  parameter int N_ENTRIES = 16,
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int ASID_W    = 8,
  parameter int PG_SHIFT  = 12,
  parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_va,
  input  logic [ASID_W-1:0] req_asid,
  input  logic              req_write,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_phys,
  output logic              rsp_wperm,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn,
  input  logic [VA_W-1:0]   wr_pmask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PA_W-1:0]   wr_pfn_even,
  input  logic [PA_W-1:0]   wr_pfn_odd,
  input  logic              wr_v_even,
  input  logic              wr_d_even,
  input  logic              wr_v_odd,
  input  logic              wr_d_odd
);
  logic [VA_W-1:0]      e_vpn  [N_ENTRIES];
  logic [VA_W-1:0]      e_mask [N_ENTRIES];
  logic [ASID_W-1:0]    e_asid [N_ENTRIES];
  logic [PA_W-1:0]      e_pfn0 [N_ENTRIES];
  logic [PA_W-1:0]      e_pfn1 [N_ENTRIES];
  logic [N_ENTRIES-1:0] e_glob, e_v0, e_d0, e_v1, e_d1;
  logic [N_ENTRIES-1:0] hit;
  logic                 any_hit;
  logic [IDX_W-1:0]     win_idx;
  tlb_res_e             nx_code;
  logic [PA_W-1:0]      nx_phys;
  logic                 nx_wperm;
  logic                 req_fire;

  tlb_pair_store #(
    .N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .PA_W(PA_W),
    .ASID_W(ASID_W), .PG_SHIFT(PG_SHIFT), .IDX_W(IDX_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
    .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_v_even(wr_v_even), .wr_d_even(wr_d_even),
    .wr_v_odd(wr_v_odd), .wr_d_odd(wr_d_odd),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid),
    .e_pfn0(e_pfn0), .e_pfn1(e_pfn1), .e_glob(e_glob),
    .e_v0(e_v0), .e_d0(e_d0), .e_v1(e_v1), .e_d1(e_d1)
  );

  tlb_pair_cmp #(.N_ENTRIES(N_ENTRIES), .VA_W(VA_W), .ASID_W(ASID_W)) u_cmp (
    .va(req_va), .asid(req_asid),
    .e_vpn(e_vpn), .e_mask(e_mask), .e_asid(e_asid), .e_glob(e_glob),
    .hit(hit)
  );

  tlb_pair_pick #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_pick (
    .hit(hit), .any_hit(any_hit), .win_idx(win_idx)
  );

  tlb_pair_xlate #(.VA_W(VA_W), .PA_W(PA_W)) u_xlate (
    .any_hit(any_hit), .is_write(req_write), .va(req_va),
    .mask(e_mask[win_idx]), .pfn0(e_pfn0[win_idx]), .pfn1(e_pfn1[win_idx]),
    .v0(e_v0[win_idx]), .d0(e_d0[win_idx]),
    .v1(e_v1[win_idx]), .d1(e_d1[win_idx]),
    .code(nx_code), .phys(nx_phys), .wperm(nx_wperm)
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign req_fire  = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_code  <= RES_NOMATCH;
      rsp_phys  <= '0;
      rsp_wperm <= 1'b0;
    end else if (req_fire) begin
      rsp_valid <= 1'b1;
      rsp_code  <= nx_code;
      rsp_phys  <= nx_phys;
      rsp_wperm <= nx_wperm;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/tlb_pair_chk.sv
module tlb_pair_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [1:0]      rsp_code,
  input logic [PA_W-1:0] rsp_phys,
  input logic            rsp_wperm
);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code)
                               && $stable(rsp_phys) && $stable(rsp_wperm));

  a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid);

  a_r10_drain: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) && rsp_ready |=> !rsp_valid);

  a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);

  // R4, R6 and R8: every fault code carries no address and no permission
  a_r4_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_code != 2'd0 |-> rsp_phys == '0 && !rsp_wperm);

  a_r7_wperm_match: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_wperm |-> rsp_code == 2'd0);
endmodule

bind tlb_pair_lookup tlb_pair_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
  .rsp_phys(rsp_phys), .rsp_wperm(rsp_wperm)
);

// File: tb/tlb_pair_lookup_tb_top.sv
`timescale 1ns/1ps
module tlb_pair_lookup_tb_top;
  localparam int NE = 6;
  localparam int IW = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [31:0] req_va = '0;
  logic [7:0]  req_asid = '0;
  logic        req_ready, rsp_valid, rsp_wperm;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_phys;
  logic        wr_en = 1'b0, wr_global = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_vpn = '0, wr_pmask = '0, wr_pfn_even = '0, wr_pfn_odd = '0;
  logic [7:0]  wr_asid = '0;
  logic        wr_v_even = 1'b0, wr_d_even = 1'b0, wr_v_odd = 1'b0, wr_d_odd = 1'b0;

  always #4 clk = ~clk;

  tlb_pair_lookup #(.N_ENTRIES(NE), .VA_W(32), .PA_W(32), .ASID_W(8), .PG_SHIFT(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .req_asid(req_asid), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code),
    .rsp_phys(rsp_phys), .rsp_wperm(rsp_wperm),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn(wr_vpn), .wr_pmask(wr_pmask),
    .wr_asid(wr_asid), .wr_global(wr_global),
    .wr_pfn_even(wr_pfn_even), .wr_pfn_odd(wr_pfn_odd),
    .wr_v_even(wr_v_even), .wr_d_even(wr_d_even),
    .wr_v_odd(wr_v_odd), .wr_d_odd(wr_d_odd)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R12";

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Behavioural reference table
  logic [31:0] m_vpn [NE], m_pm [NE], m_p0 [NE], m_p1 [NE];
  logic [7:0]  m_as [NE];
  bit          m_g [NE], m_v0 [NE], m_d0 [NE], m_v1 [NE], m_d1 [NE];
  bit          m_rv;
  logic [1:0]  m_code;
  logic [31:0] m_phys;
  bit          m_wp;

  task automatic model_lookup(input logic [31:0] va, input logic [7:0] as, input bit wr,
                              output logic [1:0] code, output logic [31:0] ph, output bit wp);
    int k = -1;
    code = 2'd1; ph = '0; wp = 1'b0;
    for (int i = 0; i < NE; i++) begin
      logic [31:0] msk = m_pm[i] | 32'h1FFF;
      if (k < 0 && (m_g[i] || m_as[i] == as) && ((m_vpn[i] & ~msk) == (va & ~msk))) k = i;
    end
    if (k >= 0) begin
      logic [31:0] msk = m_pm[k] | 32'h1FFF;
      int top = 0;
      bit odd, v, d;
      for (int b = 0; b < 32; b++) if (msk[b]) top = b;
      odd = va[top];
      v = odd ? m_v1[k] : m_v0[k];
      d = odd ? m_d1[k] : m_d0[k];
      if (!v) code = 2'd2;
      else if (wr && !d) code = 2'd3;
      else begin
        code = 2'd0;
        ph = (odd ? m_p1[k] : m_p0[k]) | (va & (msk >> 1));
        wp = d;
      end
    end
  endtask

  // Cycle-by-cycle comparison against the reference, at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      m_rv = 1'b0;
      for (int i = 0; i < NE; i++) begin
        m_vpn[i] = '0; m_pm[i] = '0; m_p0[i] = '0; m_p1[i] = '0; m_as[i] = '0;
        m_g[i] = 0; m_v0[i] = 0; m_d0[i] = 0; m_v1[i] = 0; m_d1[i] = 0;
      end
    end else begin
      bit fire;
      chk(cur_req, "rsp_valid", {31'd0, rsp_valid}, {31'd0, m_rv});
      chk("R10", "req_ready", {31'd0, req_ready}, {31'd0, (!m_rv || rsp_ready)});
      if (m_rv) begin
        chk(cur_req, "rsp_code", {30'd0, rsp_code}, {30'd0, m_code});
        chk(cur_req, "rsp_phys", rsp_phys, m_phys);
        chk(cur_req, "rsp_wperm", {31'd0, rsp_wperm}, {31'd0, m_wp});
      end
      fire = req_valid && (!m_rv || rsp_ready);
      if (fire) begin
        model_lookup(req_va, req_asid, req_write, m_code, m_phys, m_wp);
        m_rv = 1'b1;
      end else if (rsp_ready) m_rv = 1'b0;
      if (wr_en && int'(wr_idx) < NE) begin  // R11 writes land after the same-edge lookup
        m_vpn[wr_idx] = wr_vpn; m_pm[wr_idx] = wr_pmask; m_as[wr_idx] = wr_asid;
        m_g[wr_idx] = wr_global; m_p0[wr_idx] = wr_pfn_even; m_p1[wr_idx] = wr_pfn_odd;
        m_v0[wr_idx] = wr_v_even; m_d0[wr_idx] = wr_d_even;
        m_v1[wr_idx] = wr_v_odd; m_d1[wr_idx] = wr_d_odd;
      end
    end
  end

  task automatic put(input int idx, input logic [31:0] vpn, input logic [31:0] pm,
                     input logic [7:0] as, input bit g, input logic [31:0] p0, input bit v0, input bit d0,
                     input logic [31:0] p1, input bit v1, input bit d1);
    @(posedge clk); #1;
    wr_en = 1; wr_idx = IW'(idx); wr_vpn = vpn; wr_pmask = pm; wr_asid = as; wr_global = g;
    wr_pfn_even = p0; wr_v_even = v0; wr_d_even = d0; wr_pfn_odd = p1; wr_v_odd = v1; wr_d_odd = d1;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic look(input string rq, input logic [31:0] va, input logic [7:0] as, input bit wr,
                      input logic [1:0] ec, input logic [31:0] ep, input bit ew);
    cur_req = rq;
    @(posedge clk); #1;
    req_valid = 1; req_va = va; req_asid = as; req_write = wr; rsp_ready = 1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 0;
    @(negedge clk);
    chk(rq, "hand valid", {31'd0, rsp_valid}, 32'd1);
    chk(rq, "hand code", {30'd0, rsp_code}, {30'd0, ec});
    chk(rq, "hand phys", rsp_phys, ep);
    chk(rq, "hand wperm", {31'd0, rsp_wperm}, {31'd0, ew});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R10 watchdog: actual timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R12", "reset rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12", "reset req_ready", {31'd0, req_ready}, 32'd1);
    // R12: cleared entry 0 (tag 0, space 0, frames invalid) hits address 0x10
    look("R12", 32'h0000_0010, 8'd0, 0, 2'd2, 32'h0, 0);

    put(0, 32'h0040_0000, 32'h0, 8'd5, 0, 32'h1000_0000, 1, 1, 32'h2000_0000, 1, 0);
    look("R5",  32'h0040_0123, 8'd5, 0, 2'd0, 32'h1000_0123, 1);
    look("R3",  32'h0040_1ABC, 8'd5, 0, 2'd0, 32'h2000_0ABC, 0);
    look("R6",  32'h0040_1ABC, 8'd5, 1, 2'd3, 32'h0, 0);
    look("R7",  32'h0040_0123, 8'd5, 1, 2'd0, 32'h1000_0123, 1);
    look("R1",  32'h0040_0123, 8'd6, 0, 2'd1, 32'h0, 0);
    look("R8",  32'h0060_0123, 8'd5, 0, 2'd1, 32'h0, 0);

    put(1, 32'h0080_0000, 32'h0000_6000, 8'd0, 1, 32'h3000_0000, 1, 1, 32'h3000_4000, 0, 0);
    look("R2",  32'h0080_2345, 8'd9, 0, 2'd0, 32'h3000_2345, 1);
    look("R4",  32'h0080_6345, 8'd9, 0, 2'd2, 32'h0, 0);
    look("R2",  32'h0080_8000, 8'd9, 0, 2'd1, 32'h0, 0);

    put(2, 32'h0100_0000, 32'h0, 8'd0, 1, 32'h4000_0000, 1, 1, 32'h0, 0, 0);
    put(3, 32'h0100_0000, 32'h0, 8'd0, 1, 32'h5000_0000, 1, 1, 32'h0, 0, 0);
    look("R9",  32'h0100_0010, 8'd1, 0, 2'd0, 32'h4000_0010, 1);
    put(2, 32'h0100_0000, 32'h0, 8'd0, 1, 32'h4000_0000, 0, 0, 32'h0, 0, 0);
    look("R9",  32'h0100_0010, 8'd1, 0, 2'd2, 32'h0, 0);

    // R11: out-of-range slot is discarded
    put(7, 32'h0200_0000, 32'h0, 8'd0, 1, 32'h7000_0000, 1, 1, 32'h0, 0, 0);
    look("R11", 32'h0200_0000, 8'd1, 0, 2'd1, 32'h0, 0);

    // R11: lookup accepted on the writing edge sees the old contents
    cur_req = "R11";
    @(posedge clk); #1;
    req_valid = 1; req_va = 32'h0300_0000; req_asid = 8'd1; req_write = 0;
    wr_en = 1; wr_idx = 3'd4; wr_vpn = 32'h0300_0000; wr_pmask = 0; wr_asid = 0; wr_global = 1;
    wr_pfn_even = 32'h6000_0000; wr_v_even = 1; wr_d_even = 1; wr_v_odd = 0; wr_d_odd = 0;
    @(posedge clk); #1;
    req_valid = 0; wr_en = 0;
    @(negedge clk);
    chk("R11", "same-edge code", {30'd0, rsp_code}, 32'd1);
    look("R11", 32'h0300_0000, 8'd1, 0, 2'd0, 32'h6000_0000, 1);

    // R10: back-pressure holds the first answer and stalls the second request
    cur_req = "R10";
    @(posedge clk); #1;
    rsp_ready = 0; req_valid = 1; req_va = 32'h0040_0123; req_asid = 8'd5; req_write = 0;
    @(posedge clk); #1;
    req_va = 32'h0080_2345;
    repeat (3) begin
      @(negedge clk);
      chk("R10", "stall ready", {31'd0, req_ready}, 32'd0);
      chk("R10", "held phys", rsp_phys, 32'h1000_0123);
    end
    @(posedge clk); #1 rsp_ready = 1;
    @(posedge clk); #1 req_valid = 0;
    @(negedge clk);
    chk("R10", "next phys", rsp_phys, 32'h3000_2345);

    // Random traffic against the reference
    cur_req = "R5";
    for (int c = 0; c < 6000; c++) begin
      bit acc;
      @(negedge clk);
      acc = req_valid && req_ready;
      @(posedge clk); #1;
      if (!req_valid || acc) begin
        int k = $urandom % NE;
        req_valid = ($urandom % 3) != 0;
        req_va = ($urandom % 5 == 0) ? $urandom : (m_vpn[k] ^ ($urandom & 32'h0001_FFFF));
        req_asid = ($urandom % 2) ? m_as[k] : 8'($urandom % 4);
        req_write = $urandom % 2;
      end
      rsp_ready = ($urandom % 4) != 0;
      wr_en = ($urandom % 8) == 0;
      wr_idx = IW'($urandom % 8);
      wr_vpn = ($urandom % 8) << 17;
      case ($urandom % 3)
        0: wr_pmask = 32'h0;
        1: wr_pmask = 32'h0000_6000;
        default: wr_pmask = 32'h0001_E000;
      endcase
      wr_asid = 8'($urandom % 4); wr_global = ($urandom % 4) == 0;
      wr_pfn_even = $urandom & 32'hFFFE_0000; wr_pfn_odd = $urandom & 32'hFFFE_0000;
      wr_v_even = $urandom % 2; wr_d_even = $urandom % 2;
      wr_v_odd = $urandom % 2; wr_d_odd = $urandom % 2;
    end
    @(posedge clk); #1;
    req_valid = 0; wr_en = 0; rsp_ready = 1;
    repeat (3) @(posedge clk);
    done = 1'b1;
    report();
  end
endmodule